// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the shared time base for a pair of PWM outputs. A two-stage prescaler turns the input clock into a one-cycle count enable. Its divide ratio is a power-of-two stage multiplied by a second stage. That second stage is 1 when its code is zero and otherwise twice its code. On each enable, a 16-bit counter steps against an active period value. It can count upward, count downward, run as a triangle (up then down), or hold still.

A 16-bit control word selects the counting mode, the two prescaler codes and the period loading style. A one-cycle write strobe with a data word supplies new period values. Each write goes either to a shadow register, which is copied into the active period when the counter returns to zero, or straight into the active period. The block drives the counter value, the counting direction, and two one-cycle strobes. The strobes mark the counter arriving at zero and at the period. Downstream compare and output logic uses these outputs.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, direction flag and both event strobes are cleared to 0, and the prescaler restarts its division.
- R2: With mode code 00 in control bits [1:0] (count up), each enable step adds one, and a counter at or above the active period steps to 0. `tb_dir_down` is 0.
- R3: With mode code 01 (count down), each step subtracts one, and a counter at 0 steps to the active period. `tb_dir_down` is 1.
- R4: With mode code 10 (triangle), the counter rises to the period and then falls to 0, repeating without visiting either endpoint twice in a row. `tb_dir_down` is 1 for values reached while falling, including 0, and 0 for values reached while rising, including the period.
- R5: With mode code 11 (hold), the counter and direction keep their values and no event strobe is raised.
- R6: Clock cycles per count step equal 2^A × B. A is the code in control bits [12:10]. B is 1 when the code in bits [9:7] is 0, and otherwise twice that code.
- R7: The counter changes only at a clock edge where the prescaler enable is high. Between enables it holds its value.
- R8: With control bit 3 at 0 (shadow loading), a period write is stored aside. It becomes the active period at the step that brings the counter to 0, and the old period governs until then.
- R9: With control bit 3 at 1 (immediate loading), a period write replaces the active period at once. An up-counter already above the new period steps to 0 at its next step.
- R10: `tb_zero_evt` / `tb_prd_evt` are high for exactly one clock cycle. That cycle is the one in which `tb_cnt` first shows the value reached by a step that landed on 0 / on the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | CTL_W (16) | Mode [1:0], load select [3], second-stage code [9:7], power-of-two code [12:10] |
| prd_wr_en | input | 1 | One-cycle period write strobe |
| prd_wr_data | input | CNT_W (16) | Period value to write |
| tb_cnt | output | CNT_W (16) | Current counter value |
| tb_dir_down | output | 1 | 1 while counting downward |
| tb_zero_evt | output | 1 | One-cycle strobe: counter arrived at 0 |
| tb_prd_evt | output | 1 | One-cycle strobe: counter arrived at the period |

## Verification
The hardest case to reach is a period write that lands mid-cycle while the counter is already past the new value. In shadow mode the write must stay invisible until the next zero. In immediate mode it must force an early wrap. The stimulus first programs a period through immediate loading and starts counting up. It then watches for a chosen counter value and issues the write at that sample, so the expected trajectory is known step by step. The prescaler table walk reaches the large divide ratios by timing the gap between two successive counter changes.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_TRI  = 2'b10,
    CM_HOLD = 2'b11
  } cnt_mode_e;

  // control word field positions
  localparam int MODE_LSB = 0;
  localparam int LDSEL_BIT = 3;
  localparam int HSP_LSB = 7;
  localparam int PW2_LSB = 10;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int CODE_W  = 3,
  parameter int RATIO_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] pw2_code,
  input  logic [CODE_W-1:0] hsp_code,
  output logic              tick
);
  logic [RATIO_W-1:0] stage_b;
  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] limit;
  logic [RATIO_W-1:0] div_cnt;

  always_comb begin
    stage_b = (hsp_code == '0) ? RATIO_W'(1) : RATIO_W'({hsp_code, 1'b0});
    ratio   = stage_b << pw2_code;
    limit   = ratio - 1'b1;
  end

  // >= keeps the divider safe when the ratio shrinks mid-count
  assign tick = (div_cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst)       div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int                CNT_W   = 16,
  parameter logic [CNT_W-1:0]  RST_PRD = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             imm_sel,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] active
);
  logic [CNT_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_PRD;
      active <= RST_PRD;
    end else begin
      if (wr_en) shadow <= wr_data;
      if (wr_en && imm_sel) active <= wr_data;
      else if (load)        active <= wr_en ? wr_data : shadow;
    end
  end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] prd,
  output logic             zero_hit,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             zero_evt,
  output logic             prd_evt
);
  logic [CNT_W-1:0] cnt_n;
  logic             dir_n;
  logic             moving;
  logic             step;

  always_comb begin
    cnt_n  = cnt;
    dir_n  = dir_down;
    moving = 1'b1;
    unique case (mode)
      CM_UP: begin
        dir_n = 1'b0;
        cnt_n = (cnt >= prd) ? '0 : cnt + 1'b1;
      end
      CM_DOWN: begin
        dir_n = 1'b1;
        cnt_n = (cnt == '0) ? prd : cnt - 1'b1;
      end
      CM_TRI: begin
        dir_n = dir_down ? (cnt != '0) : (cnt >= prd);
        if (prd == '0)  cnt_n = '0;
        else if (dir_n) cnt_n = cnt - 1'b1;
        else            cnt_n = cnt + 1'b1;
      end
      default: moving = 1'b0;
    endcase
  end

  assign step     = tick && moving;
  assign zero_hit = step && (cnt_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      zero_evt <= 1'b0;
      prd_evt  <= 1'b0;
    end else begin
      zero_evt <= zero_hit;
      prd_evt  <= step && (cnt_n == prd);
      if (step) begin
        cnt      <= cnt_n;
        dir_down <= dir_n;
      end
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter int               CTL_W   = 16,
  parameter int               CODE_W  = 3,
  parameter logic [CNT_W-1:0] RST_PRD = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             prd_wr_en,
  input  logic [CNT_W-1:0] prd_wr_data,
  output logic [CNT_W-1:0] tb_cnt,
  output logic             tb_dir_down,
  output logic             tb_zero_evt,
  output logic             tb_prd_evt
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int RATIO_W  = MAX_CODE + $clog2(2 * MAX_CODE + 1);

  logic             pre_tick;
  logic             load_now;
  logic [CNT_W-1:0] active_prd;
  cnt_mode_e        mode;

  assign mode = cnt_mode_e'(ctl_word[MODE_LSB +: 2]);

  pwm_tb_prescaler #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) pre_i (
    .clk      (clk),
    .rst      (rst),
    .pw2_code (ctl_word[PW2_LSB +: CODE_W]),
    .hsp_code (ctl_word[HSP_LSB +: CODE_W]),
    .tick     (pre_tick)
  );

  pwm_tb_period #(.CNT_W(CNT_W), .RST_PRD(RST_PRD)) prd_i (
    .clk     (clk),
    .rst     (rst),
    .imm_sel (ctl_word[LDSEL_BIT]),
    .wr_en   (prd_wr_en),
    .wr_data (prd_wr_data),
    .load    (load_now),
    .active  (active_prd)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (pre_tick),
    .mode     (mode),
    .prd      (active_prd),
    .zero_hit (load_now),
    .cnt      (tb_cnt),
    .dir_down (tb_dir_down),
    .zero_evt (tb_zero_evt),
    .prd_evt  (tb_prd_evt)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_down,
  input logic             zero_evt
);
  AST_ZERO_VAL: assert property (@(posedge clk) disable iff (rst)
    zero_evt |-> (cnt == '0)); // R10
  AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    zero_evt |-> $past(tick)); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (cnt == $past(cnt) && !zero_evt)); // R5
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0)); // R2
  AST_UP_DIR: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && tick) |=> !dir_down); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || $past(cnt) == '0)); // R3
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> $past(tick)); // R7
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode     (ctl_word[1:0]),
  .tick     (pre_tick),
  .cnt      (tb_cnt),
  .dir_down (tb_dir_down),
  .zero_evt (tb_zero_evt)
);

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  localparam int V_PW2 [NV] = '{0, 0, 1, 2, 3, 1, 0, 3};
  localparam int V_HSP [NV] = '{0, 1, 0, 3, 7, 5, 2, 0};
  localparam int V_RAT [NV] = '{1, 2, 2, 24, 112, 20, 4, 8};
  localparam int SH_EXP [7] = '{4, 5, 0, 1, 2, 0, 1};
  localparam int IM_EXP [4] = '{0, 1, 2, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctl_word = '0;
  logic        prd_wr_en = 1'b0;
  logic [15:0] prd_wr_data = '0;
  logic [15:0] tb_cnt;
  logic        tb_dir_down, tb_zero_evt, tb_prd_evt;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_timebase dut_i (
    .clk(clk), .rst(rst), .ctl_word(ctl_word),
    .prd_wr_en(prd_wr_en), .prd_wr_data(prd_wr_data),
    .tb_cnt(tb_cnt), .tb_dir_down(tb_dir_down),
    .tb_zero_evt(tb_zero_evt), .tb_prd_evt(tb_prd_evt)
  );

  function automatic logic [15:0] mk_ctl(input int mode, input int imm, input int hsp, input int pw2);
    return {3'b000, 3'(pw2), 3'(hsp), 3'b000, 1'(imm), 1'b0, 2'(mode)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    prd_wr_en = 1'b0;
    ctl_word = mk_ctl(3, 1, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 cnt", tb_cnt, 0);
    check("R1 dir", tb_dir_down, 0);
    check("R1 zero_evt", tb_zero_evt, 0);
    check("R1 prd_evt", tb_prd_evt, 0);
    rst = 1'b0;
  endtask

  task automatic wr_prd(input int p);
    prd_wr_en = 1'b1;
    prd_wr_data = 16'(p);
    @(negedge clk);
    prd_wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements) act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // prescaler table walk: R6 ratio, R7 hold between enables
    for (int v = 0; v < NV; v++) begin
      int prev, gap, guard;
      do_reset();
      wr_prd(1000);
      ctl_word = mk_ctl(0, 1, V_HSP[v], V_PW2[v]);
      @(negedge clk);
      prev = tb_cnt; guard = 0;
      while (tb_cnt == 16'(prev) && guard < 500) begin @(negedge clk); guard++; end
      for (int r = 0; r < 2; r++) begin
        prev = tb_cnt; gap = 0;
        while (tb_cnt == 16'(prev) && gap < 500) begin @(negedge clk); gap++; end
        check("R6 R7 divide ratio", gap, V_RAT[v]);
      end
    end

    // up count R2, then hold R5
    do_reset();
    wr_prd(4);
    ctl_word = mk_ctl(0, 1, 0, 0);
    for (int i = 0; i < 12; i++) begin
      int e;
      @(negedge clk);
      e = (i + 1) % 5;
      check("R2 up cnt", tb_cnt, e);
      check("R2 up dir", tb_dir_down, 0);
      check("R10 up zero_evt", tb_zero_evt, int'(e == 0));
      check("R10 up prd_evt", tb_prd_evt, int'(e == 4));
    end
    ctl_word = mk_ctl(3, 1, 0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R5 hold cnt", tb_cnt, 2);
      check("R5 hold evt", tb_zero_evt | tb_prd_evt, 0);
    end

    // down count R3
    do_reset();
    wr_prd(3);
    ctl_word = mk_ctl(1, 1, 0, 0);
    for (int i = 0; i < 9; i++) begin
      int e;
      @(negedge clk);
      e = 3 - (i % 4);
      check("R3 down cnt", tb_cnt, e);
      check("R3 down dir", tb_dir_down, 1);
      check("R10 down zero_evt", tb_zero_evt, int'(e == 0));
    end

    // triangle R4
    do_reset();
    wr_prd(3);
    ctl_word = mk_ctl(2, 1, 0, 0);
    for (int i = 0; i < 14; i++) begin
      int k, e;
      @(negedge clk);
      k = (i + 1) % 6;
      e = (k <= 3) ? k : 6 - k;
      check("R4 tri cnt", tb_cnt, e);
      check("R4 tri dir", tb_dir_down, int'(k > 3 || k == 0));
      check("R10 tri prd_evt", tb_prd_evt, int'(e == 3));
    end

    // shadow load R8
    do_reset();
    wr_prd(5);
    ctl_word = mk_ctl(0, 1, 0, 0);
    repeat (2) @(negedge clk);
    check("R8 pre cnt", tb_cnt, 2);
    ctl_word = mk_ctl(0, 0, 0, 0);
    prd_wr_en = 1'b1;
    prd_wr_data = 16'd2;
    @(negedge clk);
    prd_wr_en = 1'b0;
    check("R8 shadow cnt", tb_cnt, 3);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check("R8 shadow cnt", tb_cnt, SH_EXP[i]);
    end

    // immediate load R9
    do_reset();
    wr_prd(6);
    ctl_word = mk_ctl(0, 1, 0, 0);
    repeat (4) @(negedge clk);
    check("R9 pre cnt", tb_cnt, 4);
    prd_wr_en = 1'b1;
    prd_wr_data = 16'd2;
    @(negedge clk);
    prd_wr_en = 1'b0;
    check("R9 imm cnt", tb_cnt, 5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 imm cnt", tb_cnt, IM_EXP[i]);
      check("R9 imm prd_evt", tb_prd_evt, int'(IM_EXP[i] == 2));
    end

    // single-cycle strobes with divide 2: R10
    do_reset();
    wr_prd(2);
    ctl_word = mk_ctl(0, 1, 1, 0);
    begin
      int pulses, prev_evt;
      pulses = 0; prev_evt = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tb_zero_evt) begin
          check("R10 pulse gap", prev_evt, 0);
          check("R10 pulse cnt", tb_cnt, 0);
          pulses++;
        end
        prev_evt = tb_zero_evt;
      end
      check("R10 pulse count", int'(pulses >= 6 && pulses <= 7), 1);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule